// File: doc/BRIEF.md
# Thread Block Dispatcher

The dispatcher takes one launch request at a time. A request gives a grid size, counted in thread blocks, and a block size, counted in threads. The dispatcher then places the blocks of that grid, one per cycle at most, onto a small array of multithreaded cores.

For each core it keeps two running totals: how many blocks the core holds and how many threads those blocks add up to. A block goes to a core only when both totals still have room for it. Each placed block carries three things:

- its index within the grid;
- a base thread ID, equal to the index times the block size;
- the number of 32-thread warps the block splits into.

Each core raises a one-cycle completion line when a block finishes. The dispatcher then gives back that block's slot and threads, so a stalled grid can move again. When every block has been placed and has reported back, the dispatcher pulses a grid-done output and returns to idle.

Top module: `block_dispatcher`

## Requirements
- R1: After reset, `busy`, `dispatch_valid`, `launch_error` and `grid_done` are all low.
- R2: A launch is rejected in each of these cases: the block size is 0, the block size is above 512, or the grid size is 0. A rejected launch makes `launch_error` high for exactly the one cycle after the launch is sampled, and `busy` stays low.
- R3: A valid launch sampled while idle raises `busy` one cycle later. A launch sampled while `busy` is high has no effect: it raises no error and changes neither the dispatch stream nor the grid size.
- R4: At most one block is dispatched per cycle. Block indices start at 0 and rise by one per dispatch. The first dispatch can appear no earlier than the cycle after `busy` rises.
- R5: The target core is the first core, counting upward with wrap-around, that has room. The search starts at the core after the last one that received a block. Each launch restarts the search at core 0. `dispatch_core` is the binary core index.
- R6: A core never holds more than 8 blocks at once.
- R7: The threads of all blocks a core holds never add up to more than 768.
- R8: While blocks remain and some core has room, a block is dispatched every cycle. While no core has room, nothing is dispatched; dispatch resumes once a completion frees enough room.
- R9: A completion pulse on `core_done[i]` frees one block slot and one block's worth of threads on core i. A pulse from a core that holds no block is ignored.
- R10: `dispatch_base_tid` equals the block index multiplied by the block size.
- R11: `dispatch_warps` equals the block size divided by 32, rounded up.
- R12: `grid_done` is high for exactly one cycle. That cycle is the one after the completion that brings the number of completed blocks up to the grid size. `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request strobe |
| launch_grid_blocks | input | 16 | Number of blocks in the grid |
| launch_block_threads | input | 10 | Threads per block |
| core_done | input | 4 | Per-core one-cycle block completion pulse |
| busy | output | 1 | A grid is in progress |
| launch_error | output | 1 | Pulse: the last launch was rejected |
| dispatch_valid | output | 1 | A block is placed this cycle |
| dispatch_core | output | 2 | Index of the receiving core |
| dispatch_block_id | output | 16 | Index of the block within its grid |
| dispatch_base_tid | output | 26 | First global thread ID of the block |
| dispatch_warps | output | 5 | Warp count of the block |
| grid_done | output | 1 | Pulse: every block of the grid has completed |

## Verification
The bench sweeps block sizes over a range of values:

- 1, 31, 32 and 33, which test the warp rounding on either side of a warp boundary;
- 96, where the slot and thread budgets bind at the same point;
- 128, 200, 256, 257 and 384, where the thread budget binds first;
- 511 and 512, where only one block fits per core.

Each block size is run with grids of 1, 5 and 37 blocks. Completions are held back for the first 40 cycles, so the number placed before the first completion shows which budget limits each core. After that, completions arrive every cycle or every third cycle, staggered across cores. This tests the round-robin skip and the stall-then-resume path. Some runs inject completion pulses from empty cores and a stray launch in the middle of a grid; these expose any accounting that counts an ignored event. Bad block sizes and an empty grid check the rejection path.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } disp_state_e;
endpackage

// File: rtl/core_occupancy.sv
module core_occupancy #(
    parameter int MAX_BLOCKS  = 8,
    parameter int MAX_THREADS = 768,
    parameter int TW          = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          place,
    input  logic          retire,
    input  logic [TW-1:0] blk_threads,
    output logic          fits,
    output logic          retire_ok
);
    localparam int BW = $clog2(MAX_BLOCKS + 1);
    localparam int OW = $clog2(MAX_THREADS + 1);
    localparam int SW = ((OW > TW) ? OW : TW) + 1;
    localparam logic [BW-1:0] BLK_LIM = BW'(MAX_BLOCKS);
    localparam logic [SW-1:0] THR_LIM = SW'(MAX_THREADS);

    typedef struct packed {
        logic [BW-1:0] blks;
        logic [OW-1:0] thr;
    } occ_t;

    occ_t          occ_d, occ_q;
    logic [SW-1:0] thr_sum;

    always_comb begin
        retire_ok = retire && (occ_q.blks != '0);
        thr_sum   = SW'(occ_q.thr) + SW'(blk_threads);
        fits      = (occ_q.blks < BLK_LIM) && (thr_sum <= THR_LIM);
        occ_d     = occ_q;
        if (place && !retire_ok) begin
            occ_d.blks = occ_q.blks + BW'(1);
            occ_d.thr  = occ_q.thr + OW'(blk_threads);
        end else if (!place && retire_ok) begin
            occ_d.blks = occ_q.blks - BW'(1);
            occ_d.thr  = occ_q.thr - OW'(blk_threads);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    // R6
    blk_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q.blks <= BLK_LIM);

    // R7
    thr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SW'(occ_q.thr) <= THR_LIM);

    // R8
    place_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        place |-> fits);

    // R9
    retire_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_ok && !place) |=> (occ_q.blks == $past(occ_q.blks) - BW'(1)));
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ptr,
    input  logic [N-1:0]  eligible,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any
);
    int cand;

    always_comb begin
        any       = |eligible;
        grant_idx = '0;
        cand      = 0;
        for (int k = N - 1; k >= 0; k--) begin
            cand = (int'(ptr) + k) % N;
            if (eligible[cand]) grant_idx = IW'(cand);
        end
        grant = any ? (N'(1) << grant_idx) : '0;
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((grant & eligible) != '0));
endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
    import dispatch_pkg::*;
#(
    parameter int NUM_CORES         = 4,
    parameter int CORE_MAX_BLOCKS   = 8,
    parameter int CORE_MAX_THREADS  = 768,
    parameter int BLOCK_MAX_THREADS = 512,
    parameter int WARP_THREADS      = 32,
    parameter int GRID_W            = 16,
    localparam int TW   = $clog2(BLOCK_MAX_THREADS + 1),
    localparam int CW   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int TIDW = GRID_W + TW,
    localparam int MAXW = (BLOCK_MAX_THREADS + WARP_THREADS - 1) / WARP_THREADS,
    localparam int WW   = $clog2(MAXW + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    input  logic [GRID_W-1:0]    launch_grid_blocks,
    input  logic [TW-1:0]        launch_block_threads,
    input  logic [NUM_CORES-1:0] core_done,
    output logic                 busy,
    output logic                 launch_error,
    output logic                 dispatch_valid,
    output logic [CW-1:0]        dispatch_core,
    output logic [GRID_W-1:0]    dispatch_block_id,
    output logic [TIDW-1:0]      dispatch_base_tid,
    output logic [WW-1:0]        dispatch_warps,
    output logic                 grid_done
);
    typedef struct packed {
        disp_state_e       state;
        logic [GRID_W-1:0] total;
        logic [GRID_W-1:0] issued;
        logic [GRID_W-1:0] retired;
        logic [TW-1:0]     bthreads;
        logic [TIDW-1:0]   base;
        logic [CW-1:0]     ptr;
        logic              dv;
        logic [CW-1:0]     dcore;
        logic [GRID_W-1:0] did;
        logic [TIDW-1:0]   dtid;
        logic [WW-1:0]     dwarps;
        logic              err;
        logic              gdone;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_CORES-1:0] fits_vec, ret_vec, grant_vec, place_vec;
    logic [CW-1:0]        grant_idx;
    logic                 grant_any;
    logic                 go;
    logic                 bad_launch;
    logic [GRID_W-1:0]    ret_sum;
    logic [GRID_W-1:0]    retired_nx;
    logic [TW:0]          warp_sum;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        core_occupancy #(
            .MAX_BLOCKS  (CORE_MAX_BLOCKS),
            .MAX_THREADS (CORE_MAX_THREADS),
            .TW          (TW)
        ) u_occ (
            .clk         (clk),
            .rst_n       (rst_n),
            .place       (place_vec[g]),
            .retire      (core_done[g]),
            .blk_threads (ctl_q.bthreads),
            .fits        (fits_vec[g]),
            .retire_ok   (ret_vec[g])
        );
    end

    rr_picker #(.N(NUM_CORES), .IW(CW)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr       (ctl_q.ptr),
        .eligible  (fits_vec),
        .grant     (grant_vec),
        .grant_idx (grant_idx),
        .any       (grant_any)
    );

    always_comb begin
        go         = (ctl_q.state == ST_RUN) && (ctl_q.issued != ctl_q.total) && grant_any;
        place_vec  = go ? grant_vec : '0;
        bad_launch = (launch_block_threads == '0)
                  || (launch_block_threads > TW'(BLOCK_MAX_THREADS))
                  || (launch_grid_blocks == '0);
        ret_sum = '0;
        for (int i = 0; i < NUM_CORES; i++) ret_sum = ret_sum + GRID_W'(ret_vec[i]);
        retired_nx = ctl_q.retired + ret_sum;
        warp_sum   = {1'b0, ctl_q.bthreads} + (TW+1)'(WARP_THREADS - 1);

        ctl_d       = ctl_q;
        ctl_d.dv    = 1'b0;
        ctl_d.err   = 1'b0;
        ctl_d.gdone = 1'b0;

        if (ctl_q.state == ST_IDLE) begin
            if (launch_valid) begin
                if (bad_launch) begin
                    ctl_d.err = 1'b1;
                end else begin
                    ctl_d.state    = ST_RUN;
                    ctl_d.total    = launch_grid_blocks;
                    ctl_d.issued   = '0;
                    ctl_d.retired  = '0;
                    ctl_d.bthreads = launch_block_threads;
                    ctl_d.base     = '0;
                    ctl_d.ptr      = '0;
                end
            end
        end else begin
            if (go) begin
                ctl_d.dv     = 1'b1;
                ctl_d.dcore  = grant_idx;
                ctl_d.did    = ctl_q.issued;
                ctl_d.dtid   = ctl_q.base;
                ctl_d.dwarps = WW'(warp_sum / (TW+1)'(WARP_THREADS));
                ctl_d.issued = ctl_q.issued + GRID_W'(1);
                ctl_d.base   = ctl_q.base + TIDW'(ctl_q.bthreads);
                ctl_d.ptr    = (grant_idx == CW'(NUM_CORES - 1)) ? '0 : grant_idx + CW'(1);
            end
            ctl_d.retired = retired_nx;
            if (retired_nx == ctl_q.total) begin
                ctl_d.gdone = 1'b1;
                ctl_d.state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy              = (ctl_q.state == ST_RUN);
    assign launch_error      = ctl_q.err;
    assign dispatch_valid    = ctl_q.dv;
    assign dispatch_core     = ctl_q.dcore;
    assign dispatch_block_id = ctl_q.did;
    assign dispatch_base_tid = ctl_q.dtid;
    assign dispatch_warps    = ctl_q.dwarps;
    assign grid_done         = ctl_q.gdone;

    // R4
    disp_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.dv |-> $past(ctl_q.state == ST_RUN));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.gdone |-> (ctl_q.state == ST_IDLE) && !ctl_q.dv);

    // R2
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.err |-> (ctl_q.state == ST_IDLE) && $past(ctl_q.state == ST_IDLE));

    // R11
    warp_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.dv |-> (int'(ctl_q.dwarps) * WARP_THREADS >= int'(ctl_q.bthreads))
                  && ((int'(ctl_q.dwarps) - 1) * WARP_THREADS < int'(ctl_q.bthreads)));

    // R10
    first_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.dv && ctl_q.did == '0) |-> (ctl_q.dtid == '0));
endmodule

// File: tb/test_block_dispatcher.sv
module test_block_dispatcher;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_valid = 1'b0;
    logic [15:0] launch_grid_blocks = '0;
    logic [9:0]  launch_block_threads = '0;
    logic [3:0]  core_done = '0;
    logic        busy, launch_error, dispatch_valid, grid_done;
    logic [1:0]  dispatch_core;
    logic [15:0] dispatch_block_id;
    logic [25:0] dispatch_base_tid;
    logic [4:0]  dispatch_warps;

    always #2 clk = ~clk;

    block_dispatcher i_block_dispatcher (
        .clk (clk), .rst_n (rst_n),
        .launch_valid (launch_valid), .launch_grid_blocks (launch_grid_blocks),
        .launch_block_threads (launch_block_threads), .core_done (core_done),
        .busy (busy), .launch_error (launch_error), .dispatch_valid (dispatch_valid),
        .dispatch_core (dispatch_core), .dispatch_block_id (dispatch_block_id),
        .dispatch_base_tid (dispatch_base_tid), .dispatch_warps (dispatch_warps),
        .grid_done (grid_done)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    bit m_run = 0;
    int m_total, m_issued, m_retired, m_bt, m_ptr;
    int m_blks[NC];
    int m_thr[NC];
    bit last_done;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic step(input bit lv, input int lg, input int lbt, input logic [3:0] dn);
        bit bad, go, exp_done, exp_err;
        int pick, nacc;
        bit elig[NC];
        bit acc[NC];
        launch_valid         = lv;
        launch_grid_blocks   = 16'(lg);
        launch_block_threads = 10'(lbt);
        core_done            = dn;
        bad = (lbt == 0) || (lbt > 512) || (lg == 0);
        exp_err = !m_run && lv && bad;
        go = 0; pick = 0; nacc = 0;
        for (int c = 0; c < NC; c++) begin
            elig[c] = (m_blks[c] < 8) && (m_thr[c] + m_bt <= 768);
            acc[c]  = dn[c] && (m_blks[c] > 0);
            if (acc[c]) nacc++;
        end
        if (m_run && m_issued < m_total) begin
            for (int k = 0; k < NC; k++) begin
                if (!go && elig[(m_ptr + k) % NC]) begin
                    go = 1; pick = (m_ptr + k) % NC;
                end
            end
        end
        exp_done = m_run && (m_retired + nacc == m_total);
        @(negedge clk);
        chk(dispatch_valid == go, "R8", "dispatch_valid", dispatch_valid, go);
        if (go && dispatch_valid) begin
            chk(dispatch_core == 2'(pick), "R5", "dispatch_core", dispatch_core, pick);
            chk(dispatch_block_id == 16'(m_issued), "R4", "block id", dispatch_block_id, m_issued);
            chk(dispatch_base_tid == 26'(m_issued * m_bt), "R10", "base tid",
                dispatch_base_tid, m_issued * m_bt);
            chk(dispatch_warps == 5'((m_bt + 31) / 32), "R11", "warps",
                dispatch_warps, (m_bt + 31) / 32);
        end
        chk(launch_error == exp_err, "R2", "launch_error", launch_error, exp_err);
        chk(grid_done == exp_done, "R12", "grid_done", grid_done, exp_done);
        // model update
        if (go) begin
            m_blks[pick]++; m_thr[pick] += m_bt; m_issued++; m_ptr = (pick + 1) % NC;
        end
        for (int c = 0; c < NC; c++) if (acc[c]) begin m_blks[c]--; m_thr[c] -= m_bt; end
        if (m_run) m_retired += nacc;
        if (exp_done) m_run = 0;
        else if (!m_run && lv && !bad) begin
            m_run = 1; m_total = lg; m_issued = 0; m_retired = 0; m_bt = lbt; m_ptr = 0;
        end
        last_done = exp_done;
        chk(busy == m_run, "R3", "busy", busy, m_run);
        launch_valid = 1'b0;
        core_done    = '0;
    endtask

    task automatic run_grid(input int grid, input int bt, input int period, input bit spur);
        int cyc, cap, lim;
        logic [3:0] dn;
        bit stray;
        lim = 768 / bt;
        if (lim > 8) lim = 8;
        cap = NC * lim;
        if (cap > grid) cap = grid;
        step(1, grid, bt, 4'b0);
        cyc = 0;
        last_done = 0;
        while (!last_done && cyc < 4000) begin
            dn = '0;
            for (int c = 0; c < NC; c++) begin
                if (cyc >= 40 && m_blks[c] > 0 && ((cyc + c) % period == 0)) dn[c] = 1'b1;
                if (spur && (cyc % 9 == 4) && m_blks[c] == 0) dn[c] = 1'b1; // R9 empty-core pulse
            end
            if (cyc == 40)
                chk(m_issued == cap, (bt * 8 <= 768) ? "R6" : "R7", "blocks placed before any completion",
                    m_issued, cap);
            stray = spur && (cyc == 10); // R3 launch while busy must be ignored
            step(stray, 3, 64, dn);
            cyc++;
        end
        chk(last_done, "R12", "grid finished", last_done, 1);
        chk(busy == 1'b0, spur ? "R9" : "R12", "busy after grid", busy, 0);
        step(0, 0, 0, 4'b0);
    endtask

    initial begin
        int bts[12] = '{1, 31, 32, 33, 96, 128, 200, 256, 257, 384, 511, 512};
        int grids[3] = '{1, 5, 37};
        for (int c = 0; c < NC; c++) begin m_blks[c] = 0; m_thr[c] = 0; end
        m_bt = 1; m_total = 0; m_issued = 0; m_retired = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy == 0 && dispatch_valid == 0 && launch_error == 0 && grid_done == 0,
            "R1", "outputs after reset", {busy, dispatch_valid, launch_error, grid_done}, 0);
        // R2 rejections
        step(1, 5, 0, 4'b0);
        step(0, 0, 0, 4'b0);
        step(1, 5, 513, 4'b0);
        step(1, 5, 1023, 4'b0);
        step(1, 0, 64, 4'b0);
        step(0, 0, 0, 4'b0);
        for (int b = 0; b < 12; b++)
            for (int g = 0; g < 3; g++)
                for (int p = 0; p < 2; p++)
                    run_grid(grids[g], bts[b], (p == 0) ? 1 : 3, (b + g + p) % 2 == 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule